// File: doc/BRIEF.md
# Prioritized Trap Cause Selector

This block arbitrates among every trap cause that is pending in a processor pipeline in a given cycle. It picks the single cause that must be taken and reports its 9-bit trap type code, its priority number and a valid flag. Some causes are plain request bits, each with a fixed code and priority. Others carry an index: an interrupt level, a register-window type for spill and fill traps, or a software trap number. For these the code is built by adding the index to a base value. The block does not detect causes and does not dispatch handlers. It only arbitrates and encodes.

Each cause has a priority number, and several causes can share the same number. A lower number is more urgent. When the best number is shared, the cause with the lower trap code is chosen, so the result is always deterministic. The selection is combinational. A parameter can place a register on the result, which adds one cycle of latency. Other parameters remove the interrupt, window or software-trap candidates when a core does not need them.

The outputs are plain status pins. The block has no handshake and applies no back-pressure: a new set of requests is evaluated in every cycle.

Top module: `trapsel_top`

## Requirements
- R1: Power-on reset (`fixed_req[0]`, code 0x001, priority 0) wins over every other request, whatever else is pending.
- R2: Each `fixed_req` bit has its own code and priority, written bit:code/priority: 0:001/0, 1:002/1, 2:003/1, 3:004/1, 4:005/1, 5:008/5, 6:009/2, 7:00A/3, 8:010/7, 9:011/6, 10:012/6, 11:013/6, 12:020/8, 13:021/11, 14:022/11, 15:023/14, 16:024/10, 17:028/15, 18:029/4, 19:030/12, 20:031/12, 21:032/12, 22:033/12, 23:034/10, 24:035/10, 25:036/10, 26:037/11, 27:038/10, 28:039/10, 29:040/2. Among the pending requests, the one with the lowest priority number is selected.
- R3: When two or more pending requests share the lowest priority number, the one with the smallest trap code is selected.
- R4: A nonzero `irq_lvl` value n requests an interrupt with code 0x040+n and priority 32-n. A value of 0 means no interrupt is requested.
- R5: `win_req` bit k (0 = spill normal, 1 = spill other, 2 = fill normal, 3 = fill other) requests a window trap. Its code is 0x080 + 0x20*k + 4*t, where t is `win_type[3k+2:3k]`, and its priority is 9.
- R6: `sw_req` requests a software trap with code 0x100 + `sw_num` and priority 16.
- R7: When no request is pending, `trap_valid`, `trap_code` and `trap_prio` are all zero.
- R8: With the default output register, the outputs show the selection for the inputs of the previous clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_req | input | 30 | One bit per fixed-code cause |
| irq_lvl | input | 4 | Pending interrupt level, 0 = none |
| win_req | input | 4 | Spill/fill window trap requests |
| win_type | input | 12 | 3-bit window type per window request |
| sw_req | input | 1 | Software trap request |
| sw_num | input | 7 | Software trap number |
| trap_valid | output | 1 | A cause was selected |
| trap_code | output | 9 | Trap type code of the selected cause |
| trap_prio | output | 5 | Priority number of the selected cause |

## Verification
The properties assume the default configuration: registered outputs and all indexed candidates enabled. Under that assumption, every input combination is legal. The assertions assume nothing about how many requests are active at once. The software-trap property fires only when that request is the sole one pending. The random stimulus thins the fixed request bits by ANDing several random words together and leaves the vector empty for about a quarter of the vectors. As a result, lone requests, ties within one priority group and completely idle cycles all occur often. Directed vectors add the boundary cases: interrupt levels 0, 1 and 15, window type 7, software trap number 127, and every request active at once.

// File: rtl/trapsel_pkg.sv
package trapsel_pkg;

  localparam int CODE_W = 9;
  localparam int PRIO_W = 5;
  localparam int NFIX   = 30;
  localparam int LVL_W  = 4;
  localparam int NWIN   = 4;
  localparam int WT_W   = 3;
  localparam int SWN_W  = 7;
  localparam int NIDX   = 2 + NWIN;  // interrupt, windows, software trap

  localparam logic [CODE_W-1:0] IRQ_BASE   = 9'h040;
  localparam logic [CODE_W-1:0] WIN_BASE   = 9'h080;
  localparam logic [CODE_W-1:0] WIN_STRIDE = 9'h020;
  localparam logic [CODE_W-1:0] SW_BASE    = 9'h100;
  localparam logic [PRIO_W-1:0] WIN_PRIO   = 5'd9;
  localparam logic [PRIO_W-1:0] SW_PRIO    = 5'd16;
  localparam int                IRQ_TOP    = 32;

  typedef struct packed {
    logic              vld;
    logic [CODE_W-1:0] code;
    logic [PRIO_W-1:0] prio;
  } trap_cand_t;

  // Code assigned to each fixed request bit.
  function automatic logic [CODE_W-1:0] fix_code(input int unsigned i);
    case (i)
      0:  return 9'h001;  1:  return 9'h002;  2:  return 9'h003;
      3:  return 9'h004;  4:  return 9'h005;  5:  return 9'h008;
      6:  return 9'h009;  7:  return 9'h00A;  8:  return 9'h010;
      9:  return 9'h011;  10: return 9'h012;  11: return 9'h013;
      12: return 9'h020;  13: return 9'h021;  14: return 9'h022;
      15: return 9'h023;  16: return 9'h024;  17: return 9'h028;
      18: return 9'h029;  19: return 9'h030;  20: return 9'h031;
      21: return 9'h032;  22: return 9'h033;  23: return 9'h034;
      24: return 9'h035;  25: return 9'h036;  26: return 9'h037;
      27: return 9'h038;  28: return 9'h039;  29: return 9'h040;
      default: return '0;
    endcase
  endfunction

  // Priority number of each fixed request bit (lower = more urgent).
  function automatic logic [PRIO_W-1:0] fix_prio(input int unsigned i);
    case (i)
      0:  return 5'd0;   1:  return 5'd1;   2:  return 5'd1;
      3:  return 5'd1;   4:  return 5'd1;   5:  return 5'd5;
      6:  return 5'd2;   7:  return 5'd3;   8:  return 5'd7;
      9:  return 5'd6;   10: return 5'd6;   11: return 5'd6;
      12: return 5'd8;   13: return 5'd11;  14: return 5'd11;
      15: return 5'd14;  16: return 5'd10;  17: return 5'd15;
      18: return 5'd4;   19: return 5'd12;  20: return 5'd12;
      21: return 5'd12;  22: return 5'd12;  23: return 5'd10;
      24: return 5'd10;  25: return 5'd10;  26: return 5'd11;
      27: return 5'd10;  28: return 5'd10;  29: return 5'd2;
      default: return '1;
    endcase
  endfunction

  // True when candidate b must be taken instead of candidate a.
  // The key {prio, code} orders first by urgency, then by code.
  function automatic logic prefer(input trap_cand_t a, input trap_cand_t b);
    return b.vld && (!a.vld || ({b.prio, b.code} < {a.prio, a.code}));
  endfunction

endpackage

// File: rtl/trapsel_fixed.sv
module trapsel_fixed
  import trapsel_pkg::*;
(
  input  logic [NFIX-1:0]        req,
  output trap_cand_t [NFIX-1:0]  cand
);
  for (genvar i = 0; i < NFIX; i++) begin : g_fix
    assign cand[i].vld  = req[i];
    assign cand[i].code = fix_code(i);
    assign cand[i].prio = fix_prio(i);
  end
endmodule

// File: rtl/trapsel_indexed.sv
module trapsel_indexed
  import trapsel_pkg::*;
#(
  parameter bit HAS_IRQ = 1'b1,
  parameter bit HAS_WIN = 1'b1,
  parameter bit HAS_SW  = 1'b1
) (
  input  logic [LVL_W-1:0]       irq_lvl,
  input  logic [NWIN-1:0]        win_req,
  input  logic [NWIN*WT_W-1:0]   win_type,
  input  logic                   sw_req,
  input  logic [SWN_W-1:0]       sw_num,
  output trap_cand_t [NIDX-1:0]  cand
);
  localparam int IRQ_SLOT = 0;
  localparam int WIN_SLOT = 1;
  localparam int SW_SLOT  = 1 + NWIN;

  if (HAS_IRQ) begin : g_irq
    assign cand[IRQ_SLOT].vld  = (irq_lvl != '0);
    assign cand[IRQ_SLOT].code = IRQ_BASE + CODE_W'(irq_lvl);
    assign cand[IRQ_SLOT].prio = PRIO_W'(IRQ_TOP - int'(irq_lvl));
  end else begin : g_no_irq
    assign cand[IRQ_SLOT] = '0;
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    if (HAS_WIN) begin : g_on
      logic [WT_W-1:0] wt;
      assign wt = win_type[k*WT_W +: WT_W];
      assign cand[WIN_SLOT+k].vld  = win_req[k];
      assign cand[WIN_SLOT+k].code = WIN_BASE + CODE_W'(k) * WIN_STRIDE
                                     + CODE_W'({wt, 2'b00});
      assign cand[WIN_SLOT+k].prio = WIN_PRIO;
    end else begin : g_off
      assign cand[WIN_SLOT+k] = '0;
    end
  end

  if (HAS_SW) begin : g_sw
    assign cand[SW_SLOT].vld  = sw_req;
    assign cand[SW_SLOT].code = SW_BASE + CODE_W'(sw_num);
    assign cand[SW_SLOT].prio = SW_PRIO;
  end else begin : g_no_sw
    assign cand[SW_SLOT] = '0;
  end
endmodule

// File: rtl/trapsel_pick.sv
module trapsel_pick
  import trapsel_pkg::*;
(
  input  trap_cand_t a,
  input  trap_cand_t b,
  output trap_cand_t y
);
  assign y = prefer(a, b) ? b : a;
endmodule

// File: rtl/trapsel_tree.sv
module trapsel_tree
  import trapsel_pkg::*;
#(
  parameter int N = 8
) (
  input  trap_cand_t [N-1:0] leaf,
  output trap_cand_t         best
);
  localparam int LVLS = (N > 1) ? $clog2(N) : 1;
  localparam int NP   = 1 << LVLS;

  for (genvar l = 0; l <= LVLS; l++) begin : lv
    trap_cand_t [(NP>>l)-1:0] node;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < NP; j++) begin : g_pad
        if (j < N) begin : g_real
          assign node[j] = leaf[j];
        end else begin : g_empty
          assign node[j] = '0;
        end
      end
    end else begin : g_join
      for (genvar j = 0; j < (NP >> l); j++) begin : g_pair
        trapsel_pick u_pick (
          .a (lv[l-1].node[2*j]),
          .b (lv[l-1].node[2*j+1]),
          .y (node[j])
        );
      end
    end
  end

  assign best = lv[LVLS].node[0];
endmodule

// File: rtl/trapsel_top.sv
module trapsel_top
  import trapsel_pkg::*;
#(
  parameter bit HAS_IRQ = 1'b1,
  parameter bit HAS_WIN = 1'b1,
  parameter bit HAS_SW  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NFIX-1:0]       fixed_req,
  input  logic [LVL_W-1:0]      irq_lvl,
  input  logic [NWIN-1:0]       win_req,
  input  logic [NWIN*WT_W-1:0]  win_type,
  input  logic                  sw_req,
  input  logic [SWN_W-1:0]      sw_num,
  output logic                  trap_valid,
  output logic [CODE_W-1:0]     trap_code,
  output logic [PRIO_W-1:0]     trap_prio
);
  localparam int NCAND = NFIX + NIDX;

  trap_cand_t [NFIX-1:0]  fix_cand;
  trap_cand_t [NIDX-1:0]  idx_cand;
  trap_cand_t [NCAND-1:0] all_cand;
  trap_cand_t             best;
  trap_cand_t             result;

  trapsel_fixed u_fixed (
    .req  (fixed_req),
    .cand (fix_cand)
  );

  trapsel_indexed #(
    .HAS_IRQ (HAS_IRQ),
    .HAS_WIN (HAS_WIN),
    .HAS_SW  (HAS_SW)
  ) u_indexed (
    .irq_lvl  (irq_lvl),
    .win_req  (win_req),
    .win_type (win_type),
    .sw_req   (sw_req),
    .sw_num   (sw_num),
    .cand     (idx_cand)
  );

  assign all_cand = {idx_cand, fix_cand};

  trapsel_tree #(.N(NCAND)) u_tree (
    .leaf (all_cand),
    .best (best)
  );

  // Idle result is all zero, independent of the losing fields.
  assign result = best.vld ? best : '0;

  if (OUT_REG) begin : g_reg
    trap_cand_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= result;
    end
    assign trap_valid = q.vld;
    assign trap_code  = q.code;
    assign trap_prio  = q.prio;
  end else begin : g_comb
    assign trap_valid = result.vld;
    assign trap_code  = result.code;
    assign trap_prio  = result.prio;
  end
endmodule

// File: rtl/trapsel_chk.sv
module trapsel_chk
  import trapsel_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NFIX-1:0]       fixed_req,
  input logic [LVL_W-1:0]      irq_lvl,
  input logic [NWIN-1:0]       win_req,
  input logic                  sw_req,
  input logic [SWN_W-1:0]      sw_num,
  input logic                  trap_valid,
  input logic [CODE_W-1:0]     trap_code,
  input logic [PRIO_W-1:0]     trap_prio
);
  logic none_pending;
  logic only_sw;
  assign none_pending = (fixed_req == '0) && (irq_lvl == '0) && (win_req == '0) && !sw_req;
  assign only_sw      = (fixed_req == '0) && (irq_lvl == '0) && (win_req == '0) && sw_req;

  if (OUT_REG) begin : g_props
    // R1
    por_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_req[0] |=> (trap_valid && trap_code == 9'h001 && trap_prio == 5'd0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      none_pending |=> (!trap_valid && trap_code == '0 && trap_prio == '0));

    // R6
    sw_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      only_sw |=> (trap_valid && trap_code == (9'h100 | {2'b00, $past(sw_num)})
                   && trap_prio == 5'd16));

    // R4
    irq_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_code[8:4] == 5'h04 && trap_code[3:0] != 4'h0)
        |-> (trap_prio == 5'(6'd32 - {2'b00, trap_code[3:0]})));

    // R5
    win_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && trap_code[8:7] == 2'b01) |-> (trap_prio == 5'd9 && trap_code[1:0] == 2'b00));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (!trap_valid && trap_code == '0 && trap_prio == '0));
  end
endmodule

bind trapsel_top trapsel_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fixed_req  (fixed_req),
  .irq_lvl    (irq_lvl),
  .win_req    (win_req),
  .sw_req     (sw_req),
  .sw_num     (sw_num),
  .trap_valid (trap_valid),
  .trap_code  (trap_code),
  .trap_prio  (trap_prio)
);

// File: tb/trapsel_top_test.sv
module trapsel_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] fixed_req = '0;
  logic [3:0]  irq_lvl = '0;
  logic [3:0]  win_req = '0;
  logic [11:0] win_type = '0;
  logic        sw_req = 1'b0;
  logic [6:0]  sw_num = '0;
  logic        trap_valid;
  logic [8:0]  trap_code;
  logic [4:0]  trap_prio;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trapsel_top uut (
    .clk (clk), .rst_n (rst_n), .fixed_req (fixed_req), .irq_lvl (irq_lvl),
    .win_req (win_req), .win_type (win_type), .sw_req (sw_req), .sw_num (sw_num),
    .trap_valid (trap_valid), .trap_code (trap_code), .trap_prio (trap_prio)
  );

  // Table of R2, bit index -> code / priority.
  function automatic int ref_code(input int i);
    int t[30] = '{'h001,'h002,'h003,'h004,'h005,'h008,'h009,'h00A,'h010,'h011,
                  'h012,'h013,'h020,'h021,'h022,'h023,'h024,'h028,'h029,'h030,
                  'h031,'h032,'h033,'h034,'h035,'h036,'h037,'h038,'h039,'h040};
    return t[i];
  endfunction
  function automatic int ref_prio(input int i);
    int t[30] = '{0,1,1,1,1,5,2,3,7,6,6,6,8,11,11,14,10,15,4,12,12,12,12,10,10,10,11,10,10,2};
    return t[i];
  endfunction

  function automatic void offer(inout bit v, inout int bc, inout int bp, input int c, input int p);
    if (!v || p < bp || (p == bp && c < bc)) begin
      v = 1'b1; bc = c; bp = p;
    end
  endfunction

  function automatic void model(output bit v, output int c, output int p);
    v = 1'b0; c = 0; p = 0;
    for (int i = 0; i < 30; i++)
      if (fixed_req[i]) offer(v, c, p, ref_code(i), ref_prio(i));
    if (irq_lvl != 0) offer(v, c, p, 'h040 + int'(irq_lvl), 32 - int'(irq_lvl));
    for (int k = 0; k < 4; k++)
      if (win_req[k]) offer(v, c, p, 'h080 + 'h20 * k + 4 * int'(win_type[3*k +: 3]), 9);
    if (sw_req) offer(v, c, p, 'h100 + int'(sw_num), 16);
  endfunction

  task automatic compare(input string tag, input bit ev, input int ec, input int ep);
    n_vec++;
    if (trap_valid !== ev || int'(trap_code) != ec || int'(trap_prio) != ep) begin
      n_bad++;
      $display("FAIL %s: got valid=%0d code=%03h prio=%0d, expected valid=%0d code=%03h prio=%0d",
               tag, trap_valid, trap_code, trap_prio, ev, ec[8:0], ep);
    end
  endtask

  // Inputs are set at the falling edge; the register samples at the next
  // rising edge and the result is read at the falling edge after it.
  task automatic run(input string tag);
    bit ev; int ec, ep;
    model(ev, ec, ep);
    @(posedge clk);
    @(negedge clk);
    compare(tag, ev, ec, ep);
  endtask

  task automatic clear();
    fixed_req = '0; irq_lvl = '0; win_req = '0; win_type = '0; sw_req = 1'b0; sw_num = '0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog: got run still active, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    // R8: outputs held at zero during reset, even with requests pending
    @(negedge clk);
    fixed_req = '1; sw_req = 1'b1;
    repeat (3) @(negedge clk);
    compare("R8 reset", 1'b0, 0, 0);
    clear();
    rst_n = 1'b1;
    @(negedge clk);

    // R7: nothing pending
    run("R7 idle");
    // R1: everything pending at once
    fixed_req = '1; irq_lvl = 4'd15; win_req = '1; win_type = '1; sw_req = 1'b1; sw_num = 7'd5;
    run("R1 all pending");
    // R3: priority-1 resets tie, lowest code wins
    clear(); fixed_req[4:1] = 4'b1111; run("R3 reset tie");
    // R3: data access group at priority 12
    clear(); fixed_req[22:19] = 4'b1110; run("R3 data group");
    // R2: tag overflow (14) beats divide by zero (15)
    clear(); fixed_req[15] = 1'b1; fixed_req[17] = 1'b1; run("R2 tag vs div");
    // R2: async error (prio 2, code 0x040) vs translation miss (prio 2, 0x009)
    clear(); fixed_req[29] = 1'b1; fixed_req[6] = 1'b1; run("R2 prio2 pair");
    // R4: level 0 is no request
    clear(); irq_lvl = 4'd0; run("R4 level zero");
    // R4: level 1 alone
    clear(); irq_lvl = 4'd1; run("R4 level one");
    // R4/R6: software trap (16) beats level 15 (17)
    clear(); irq_lvl = 4'd15; sw_req = 1'b1; sw_num = 7'd9; run("R6 sw vs irq15");
    // R6: top software trap number
    clear(); sw_req = 1'b1; sw_num = 7'd127; run("R6 sw max");
    // R5: fill-other with type 7
    clear(); win_req = 4'b1000; win_type = 12'hE00; run("R5 fill other");
    // R5: all windows, lowest code wins the priority-9 tie
    clear(); win_req = 4'b1111; win_type = 12'h53A; run("R5 window tie");
    // R5/R2: spill-other (9) beats clean window (10)
    clear(); win_req = 4'b0010; win_type = 12'h038; fixed_req[16] = 1'b1; run("R5 spill vs clean");
    clear(); run("R7 idle again");

    // Random mix, checked against the model (R1-R7 combined)
    for (int n = 0; n < 3000; n++) begin
      fixed_req = ($urandom % 4 == 0) ? 30'd0 : 30'($urandom & $urandom & $urandom);
      irq_lvl   = ($urandom % 2 == 0) ? 4'($urandom) : 4'd0;
      win_req   = 4'($urandom & $urandom);
      win_type  = 12'($urandom);
      sw_req    = ($urandom % 3 == 0);
      sw_num    = 7'($urandom);
      run("R3 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule